// File: doc/BRIEF.md
# Target Address Generation Unit

This unit sits between instruction decode and the operand fetch path of a small processor. It takes one 24-bit single-word instruction together with the current instruction address and the contents of the base and index registers. From these it forms a 20-bit target address and reports the operand access mode. It also says whether a memory fetch is needed and whether the addressing flags form an illegal combination.

The instruction word carries a 6-bit opcode, two operand-kind bits, four addressing flags and a 12-bit displacement field. The unit can form an absolute address, a base-relative address with an unsigned displacement, or a PC-relative address with a signed displacement measured from the next instruction. An index register can be added on top of any of these, but only for direct operands. All arithmetic wraps modulo 2^20.

Requests arrive on a valid/ready handshake and results leave on another. With the default registered option, the result appears one cycle after a request is accepted. It is held stable while the consumer applies back-pressure, and the input is ready whenever the output slot is empty or is being drained in the same cycle.

Top module: `tgt_addr_unit`

## Requirements
- R1: The instruction fields are decoded as follows: bits [23:18] opcode (unused here), [17:16] operand kind n,i, [15] x (index), [14] b (base), [13] p (PC-relative), [12] e (extended), [11:0] displacement. The mode output equals n,i: 2'b11 direct, 2'b01 immediate, 2'b10 indirect.
- R2: With x, b and p all clear, the target address is the 12-bit field zero-extended to 20 bits.
- R3: With b set, the target address is the low 20 bits of the base register plus the zero-extended displacement (0 to 0xFFF), modulo 2^20.
- R4: With p set, the target address is (instruction address + 3) plus the displacement read as 12-bit two's complement (-2048 to +2047), modulo 2^20.
- R5: With x set on a direct operand, the low 20 bits of the index register are added as well, alone or together with b or p.
- R6: The illegal output is 1 when b and p are both set, when x is set with n,i other than 2'b11, when e is set, or when n,i is 2'b00. For an illegal word, the target address is 0 and fetch is 0.
- R7: For a legal word, fetch is 1 for direct and indirect operands and 0 for immediate operands.
- R8: A request accepted on a rising edge (in_valid and in_ready both high) gives out_valid=1 with its result after that same edge. out_valid drops after an edge where out_ready is high and no new request is accepted.
- R9: While out_valid=1 and out_ready=0, the outputs stay stable and in_ready is 0. in_ready equals (!out_valid || out_ready).
- R10: After reset, out_valid is 0 and in_ready is 1.
- R11: Bits [23:20] of the instruction-address, base and index inputs have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| instr | input | 24 | Instruction word |
| cur_pc | input | 24 | Address of the current instruction |
| base_reg | input | 24 | Base register contents |
| index_reg | input | 24 | Index register contents |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| tgt_addr | output | 20 | Computed target address |
| mode | output | 2 | Operand kind (n,i) |
| fetch | output | 1 | A memory fetch is needed |
| illegal | output | 1 | Illegal flag combination |

## Verification
The bench builds the unit with its defaults: a 20-bit address, a 12-bit displacement and the registered output stage. That configuration exercises the one-cycle latency and the back-pressure hold.

The 20-bit width makes wrap-around cheap to reach:
- a base near 0xFFFFF combined with a small displacement;
- a PC-relative displacement of -2048 from address 0.

Register values with their top four bits set show that those bits are ignored. Each illegal flag combination is applied on its own.

// File: rtl/tgt_addr_pkg.sv
package tgt_addr_pkg;
  localparam int TA_WORD_W = 24;
  localparam int TA_DISP_W = 12;
  localparam int TA_ADDR_W = 20;
  localparam int TA_E_BIT  = TA_DISP_W;
  localparam int TA_P_BIT  = TA_DISP_W + 1;
  localparam int TA_B_BIT  = TA_DISP_W + 2;
  localparam int TA_X_BIT  = TA_DISP_W + 3;
  localparam int TA_I_BIT  = TA_DISP_W + 4;
  localparam int TA_N_BIT  = TA_DISP_W + 5;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_IMM  = 2'b01,
    KIND_IND  = 2'b10,
    KIND_DIR  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/tgt_addr_decode.sv
module tgt_addr_decode
  import tgt_addr_pkg::*;
#(
  parameter int WORD_W = TA_WORD_W,
  parameter int DISP_W = TA_DISP_W
) (
  input  logic [WORD_W-1:0] instr,
  output op_kind_e          kind,
  output logic              use_x,
  output logic              use_b,
  output logic              use_p,
  output logic [DISP_W-1:0] disp,
  output logic              bad,
  output logic              need_fetch
);
  logic ext_flag;
  logic unused_opcode;

  assign kind     = op_kind_e'(instr[DISP_W+5:DISP_W+4]);
  assign use_x    = instr[DISP_W+3];
  assign use_b    = instr[DISP_W+2];
  assign use_p    = instr[DISP_W+1];
  assign ext_flag = instr[DISP_W];
  assign disp     = instr[DISP_W-1:0];
  assign unused_opcode = ^instr[WORD_W-1:DISP_W+6];

  always_comb begin
    bad = 1'b0;
    if (kind == KIND_NONE)              bad = 1'b1;
    if (ext_flag)                       bad = 1'b1;
    if (use_b && use_p)                 bad = 1'b1;
    if (use_x && (kind != KIND_DIR))    bad = 1'b1;
    need_fetch = !bad && (kind != KIND_IMM);
  end
endmodule

// File: rtl/tgt_addr_calc.sv
module tgt_addr_calc #(
  parameter int ADDR_W = 20,
  parameter int DISP_W = 12,
  parameter int PC_STEP = 3
) (
  input  logic [DISP_W-1:0] disp,
  input  logic              use_x,
  input  logic              use_b,
  input  logic              use_p,
  input  logic              kill,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_u, disp_s, anchor, off, idx_term, next_pc;

  assign disp_u   = {{PAD_W{1'b0}}, disp};
  assign disp_s   = {{PAD_W{disp[DISP_W-1]}}, disp};
  assign next_pc  = pc + ADDR_W'(PC_STEP);
  assign idx_term = use_x ? idx : '0;

  always_comb begin
    if (use_p) begin
      anchor = next_pc;
      off    = disp_s;
    end else if (use_b) begin
      anchor = base;
      off    = disp_u;
    end else begin
      anchor = '0;
      off    = disp_u;
    end
    addr = kill ? '0 : (anchor + off + idx_term);
  end
endmodule

// File: rtl/tgt_addr_outstage.sv
module tgt_addr_outstage #(
  parameter int DATA_W = 24,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  generate
    if (REGISTERED) begin : g_reg
      logic              v_q;
      logic [DATA_W-1:0] d_q;

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      p_accept_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

      p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/tgt_addr_unit.sv
module tgt_addr_unit
  import tgt_addr_pkg::*;
#(
  parameter int WORD_W = TA_WORD_W,
  parameter int DISP_W = TA_DISP_W,
  parameter int ADDR_W = TA_ADDR_W,
  parameter int REG_W  = 24,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] instr,
  input  logic [REG_W-1:0]  cur_pc,
  input  logic [REG_W-1:0]  base_reg,
  input  logic [REG_W-1:0]  index_reg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [1:0]        mode,
  output logic              fetch,
  output logic              illegal
);
  localparam int RES_W = ADDR_W + 4;

  op_kind_e          kind;
  logic              use_x, use_b, use_p, bad, need_fetch;
  logic [DISP_W-1:0] disp;
  logic [ADDR_W-1:0] addr_c;
  logic [RES_W-1:0]  res_c, res_q;
  logic              unused_reg_hi;

  assign unused_reg_hi = ^{cur_pc[REG_W-1:ADDR_W], base_reg[REG_W-1:ADDR_W],
                           index_reg[REG_W-1:ADDR_W]};

  tgt_addr_decode #(.WORD_W(WORD_W), .DISP_W(DISP_W)) u_dec (
    .instr(instr), .kind(kind), .use_x(use_x), .use_b(use_b), .use_p(use_p),
    .disp(disp), .bad(bad), .need_fetch(need_fetch)
  );

  tgt_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PC_STEP(3)) u_calc (
    .disp(disp), .use_x(use_x), .use_b(use_b), .use_p(use_p), .kill(bad),
    .pc(cur_pc[ADDR_W-1:0]), .base(base_reg[ADDR_W-1:0]),
    .idx(index_reg[ADDR_W-1:0]), .addr(addr_c)
  );

  assign res_c = {bad, need_fetch, 2'(kind), addr_c};

  tgt_addr_outstage #(.DATA_W(RES_W), .REGISTERED(REGISTERED)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(res_c), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(res_q)
  );

  assign tgt_addr = res_q[ADDR_W-1:0];
  assign mode     = res_q[ADDR_W+1:ADDR_W];
  assign fetch    = res_q[ADDR_W+2];
  assign illegal  = res_q[ADDR_W+3];

  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (!fetch && tgt_addr == '0));

  p_imm_nofetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode == 2'b01) |-> !fetch);

  p_none_is_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode == 2'b00) |-> illegal);
endmodule

// File: tb/tgt_addr_unit_tb_top.sv
module tgt_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] instr = '0, cur_pc = '0, base_reg = '0, index_reg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] tgt_addr;
  logic [1:0]  mode;
  logic        fetch, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tgt_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .cur_pc(cur_pc), .base_reg(base_reg), .index_reg(index_reg),
    .out_valid(out_valid), .out_ready(out_ready), .tgt_addr(tgt_addr),
    .mode(mode), .fetch(fetch), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [1:0] ni, input logic [3:0] xbpe,
                                     input logic [11:0] d);
    return {6'h0C, ni, xbpe, d};
  endfunction

  task automatic model(input logic [23:0] ins, input logic [23:0] pcv, bv, xv,
                       output logic [19:0] ea, output logic fe, output logic il);
    int d;
    logic [1:0] ni;
    ni = ins[17:16];
    il = (ni == 2'b00) || ins[12] || (ins[14] && ins[13]) || (ins[15] && ni != 2'b11);
    if (ins[13]) d = ins[11] ? int'(ins[11:0]) - 4096 : int'(ins[11:0]);
    else         d = int'(ins[11:0]);
    if (ins[13])      d = d + int'(pcv[19:0]) + 3;
    else if (ins[14]) d = d + int'(bv[19:0]);
    if (ins[15])      d = d + int'(xv[19:0]);
    ea = il ? 20'h0 : 20'(d & 32'hFFFFF);
    fe = !il && ni != 2'b01;
  endtask

  task automatic apply(input string tag, input logic [23:0] ins, pcv, bv, xv);
    logic [19:0] ea;
    logic fe, il;
    model(ins, pcv, bv, xv, ea, fe, il);
    @(negedge clk);
    instr = ins; cur_pc = pcv; base_reg = bv; index_reg = xv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R8 valid"}, 32'(out_valid), 32'd1);
    chk({tag, " addr"}, 32'(tgt_addr), 32'(ea));
    chk({tag, " R1 mode"}, 32'(mode), 32'(ins[17:16]));
    chk({tag, " R7 fetch"}, 32'(fetch), 32'(fe));
    chk({tag, " R6 illegal"}, 32'(illegal), 32'(il));
  endtask

  task automatic t_reset;
    chk("R10 out_valid", 32'(out_valid), 32'd0);
    chk("R10 in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_absolute;
    apply("R2 abs direct", mk(2'b11, 4'b0000, 12'h015), 24'h0, 24'h0, 24'h0);
    apply("R2 abs imm", mk(2'b01, 4'b0000, 12'hFFF), 24'h0, 24'h0, 24'h0);
    chk("R7 imm no fetch", 32'(fetch), 32'd0);
    apply("R2 abs ind", mk(2'b10, 4'b0000, 12'h7A3), 24'h0, 24'h0, 24'h0);
  endtask

  task automatic t_base;
    apply("R3 base ind", mk(2'b10, 4'b0100, 12'hFFF), 24'h0, 24'h012340, 24'h0);
    chk("R3 base max", 32'(tgt_addr), 32'h1333F);
    apply("R3 R11 base wrap", mk(2'b11, 4'b0100, 12'h020), 24'h0, 24'hFFFFF0, 24'h0);
    chk("R3 wrap value", 32'(tgt_addr), 32'h00010);
  endtask

  task automatic t_pcrel;
    apply("R4 pc fwd", mk(2'b11, 4'b0010, 12'h00F), 24'h000003, 24'h0, 24'h0);
    chk("R4 fwd value", 32'(tgt_addr), 32'h15);
    apply("R4 pc back", mk(2'b11, 4'b0010, 12'h800), 24'h001000, 24'h0, 24'h0);
    chk("R4 back value", 32'(tgt_addr), 32'h803);
    apply("R4 pc wrap", mk(2'b01, 4'b0010, 12'h800), 24'h000000, 24'h0, 24'h0);
    chk("R4 wrap value", 32'(tgt_addr), 32'hFF803);
    apply("R4 R11 pc hi", mk(2'b10, 4'b0010, 12'hFFD), 24'hF00000, 24'h0, 24'h0);
    chk("R4 minus3 value", 32'(tgt_addr), 32'h0);
  endtask

  task automatic t_index;
    apply("R5 idx abs", mk(2'b11, 4'b1000, 12'h03F), 24'h0, 24'h0, 24'h000100);
    chk("R5 idx value", 32'(tgt_addr), 32'h13F);
    apply("R5 idx base", mk(2'b11, 4'b1100, 12'h010), 24'h0, 24'h000400, 24'hF00020);
    chk("R5 R11 idx base value", 32'(tgt_addr), 32'h430);
    apply("R5 idx pc", mk(2'b11, 4'b1010, 12'hFF0), 24'h000100, 24'h0, 24'h000008);
    chk("R5 idx pc value", 32'(tgt_addr), 32'hFB);
  endtask

  task automatic t_illegal;
    apply("R6 b and p", mk(2'b11, 4'b0110, 12'h123), 24'h10, 24'h20, 24'h0);
    apply("R6 x imm", mk(2'b01, 4'b1000, 12'h123), 24'h0, 24'h0, 24'h5);
    apply("R6 x ind", mk(2'b10, 4'b1000, 12'h123), 24'h0, 24'h0, 24'h5);
    apply("R6 ext", mk(2'b11, 4'b0001, 12'h123), 24'h0, 24'h0, 24'h0);
    apply("R6 kind none", mk(2'b00, 4'b0000, 12'h123), 24'h0, 24'h0, 24'h0);
    chk("R6 quiet addr", 32'(tgt_addr), 32'h0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    instr = mk(2'b11, 4'b0000, 12'h0AA); in_valid = 1'b1;
    @(negedge clk);
    instr = mk(2'b11, 4'b0000, 12'h0BB);
    for (int k = 0; k < 3; k++) begin
      chk("R9 held valid", 32'(out_valid), 32'd1);
      chk("R9 held addr", 32'(tgt_addr), 32'h0AA);
      chk("R9 in_ready low", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready on drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next item", 32'(tgt_addr), 32'h0BB);
    chk("R8 next valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R8 drop valid", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_absolute;
    t_base;
    t_pcrel;
    t_index;
    t_illegal;
    t_backpressure;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule